// File: doc/BRIEF.md
# Banked Scratchpad Register File

This block is a 64-cell, 8-bit register file for a small processor core, with two ways in. An instruction can name one of the sixteen low cells directly by a 4-bit number. It can also go through a 6-bit pointer register, which reaches every cell. Cells 0 to 8 are the general registers. Cell 9 and the pairs 10-11, 12-13 and 14-15 hold saved copies of other machine registers. Cells 16 to 63 can only be reached through the pointer.

The pointer has two 3-bit fields. The upper field selects one of eight 8-cell banks and the lower field selects a cell within that bank. An indirect access can step the pointer up or down, or leave it as it is. A step changes only the lower field, so a run of accesses loops around inside one bank. The bank-end flag goes high when the lower field holds 7, and firmware uses it to end a loop over a bank. The pointer can be loaded all at once, or one field at a time from a 3-bit immediate.

The block has one combinational read port and one write port that commits at the clock edge. The pointer step for a cycle is applied after that cycle's access.

Top module: `scratch_regfile`

## Requirements
- R1: An active-high synchronous reset sets the pointer to 0 and drives `bank_end` low. Cell contents are not reset.
- R2: With `rd_ind`=0, `rd_data` shows cell `rd_dir` (0 to 15) in the same cycle. With `wr_en`=1 and `wr_ind`=0, `wr_data` is stored in cell `wr_dir` at the clock edge.
- R3: With `rd_ind`=1 or `wr_ind`=1, the port uses the cell whose address is the current pointer value, taken before any update in that cycle.
- R4: `step` is encoded as 01 = increment, 10 = decrement, 00 or 11 = no change. The step is applied at the clock edge when at least one enabled port is indirect. It changes only the lower field (bits 2:0) modulo 8, and the upper field (bits 5:3) stays the same.
- R5: `step` has no effect on the pointer when neither enabled port is indirect. This includes a direct access and a cycle with no access.
- R6: `bank_end` is high exactly when pointer bits 2:0 equal 7.
- R7: `ld_op` is encoded as 01 = load the whole pointer from `ld_val`[5:0], 10 = load bits 5:3 from `ld_val`[2:0], 11 = load bits 2:0 from `ld_val`[2:0]. A field that is not loaded keeps its value. A load takes priority over a step in the same cycle.
- R8: When a cell is read and written in the same cycle, the read returns the old value. The new value can be read from the next cycle on.
- R9: Each of the 64 cells holds its own value, and cells 16 to 63 are reached through the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read access valid (qualifies the pointer step) |
| rd_ind | input | 1 | Read through the pointer instead of `rd_dir` |
| rd_dir | input | 4 | Direct read register number |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write enable |
| wr_ind | input | 1 | Write through the pointer instead of `wr_dir` |
| wr_dir | input | 4 | Direct write register number |
| wr_data | input | 8 | Write data |
| step | input | 2 | Pointer action for an indirect access |
| ld_op | input | 2 | Pointer load operation |
| ld_val | input | 6 | Pointer load value |
| isar | output | 6 | Current pointer value |
| bank_end | output | 1 | Lower pointer field equals 7 |

## Verification
The hardest cases to reach combine a pointer action with something that should override or cancel it. One is a load and a step in the same cycle. Another is a step request during a direct access. A third is a wrap from 7 to 0, or from 0 to 7, while the upper field stays fixed. The stimulus reaches these cases in two steps. First, it uses single-field loads to place the lower field next to a bank edge. Then it applies the competing action in the following cycle, and checks both the cell that was read and the pointer value after the edge.

// File: rtl/scratch_regfile.sv
module scratch_regfile #(
  parameter int DW    = 8,
  parameter int HI_W  = 3,
  parameter int LO_W  = 3,
  parameter int DIR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 rd_ind,
  input  logic [DIR_W-1:0]     rd_dir,
  output logic [DW-1:0]        rd_data,
  input  logic                 wr_en,
  input  logic                 wr_ind,
  input  logic [DIR_W-1:0]     wr_dir,
  input  logic [DW-1:0]        wr_data,
  input  logic [1:0]           step,
  input  logic [1:0]           ld_op,
  input  logic [HI_W+LO_W-1:0] ld_val,
  output logic [HI_W+LO_W-1:0] isar,
  output logic                 bank_end
);
  localparam int AW    = HI_W + LO_W;
  localparam int DEPTH = 1 << AW;

  localparam logic [1:0] STEP_UP   = 2'b01;
  localparam logic [1:0] STEP_DOWN = 2'b10;
  localparam logic [1:0] LD_FULL   = 2'b01;
  localparam logic [1:0] LD_HI     = 2'b10;
  localparam logic [1:0] LD_LO     = 2'b11;

  logic [DW-1:0]   cells [DEPTH];
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [LO_W-1:0] lo_next;
  logic            ptr_go;

  assign rd_addr  = rd_ind ? isar : AW'(rd_dir);
  assign wr_addr  = wr_ind ? isar : AW'(wr_dir);
  assign rd_data  = cells[rd_addr];
  assign ptr_go   = (rd_en && rd_ind) || (wr_en && wr_ind);
  assign bank_end = &isar[LO_W-1:0];

  always_comb begin
    lo_next = isar[LO_W-1:0];
    if (ptr_go) begin
      case (step)
        STEP_UP:   lo_next = isar[LO_W-1:0] + 1'b1;
        STEP_DOWN: lo_next = isar[LO_W-1:0] - 1'b1;
        default:   lo_next = isar[LO_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isar <= '0;
    end else begin
      case (ld_op)
        LD_FULL: isar              <= ld_val;
        LD_HI:   isar[AW-1:LO_W]   <= ld_val[HI_W-1:0];
        LD_LO:   isar[LO_W-1:0]    <= ld_val[LO_W-1:0];
        default: isar[LO_W-1:0]    <= lo_next;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/scratch_regfile_chk.sv
module scratch_regfile_chk #(
  parameter int HI_W = 3,
  parameter int LO_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic                 rd_ind,
  input logic                 wr_en,
  input logic                 wr_ind,
  input logic [1:0]           step,
  input logic [1:0]           ld_op,
  input logic [HI_W+LO_W-1:0] ld_val,
  input logic [HI_W+LO_W-1:0] isar,
  input logic                 bank_end
);
  localparam int AW = HI_W + LO_W;
  logic rst_q = 1'b0;
  logic ind_act;
  assign ind_act = (rd_en && rd_ind) || (wr_en && wr_ind);

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) AST_RESET_CLEARS: assert (isar == '0 && !bank_end); // R1

  AST_STEP_UP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b00 && ind_act && step == 2'b01) |=>
      (isar[LO_W-1:0] == LO_W'($past(isar[LO_W-1:0]) + 1'b1))); // R4

  AST_STEP_DOWN_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b00 && ind_act && step == 2'b10) |=>
      (isar[LO_W-1:0] == LO_W'($past(isar[LO_W-1:0]) - 1'b1))); // R4

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b00 || ld_op == 2'b11) |=> $stable(isar[AW-1:LO_W])); // R4

  AST_NO_STEP_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b00 && !ind_act) |=> $stable(isar)); // R5

  AST_BANK_END_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b00 && ind_act && step == 2'b01 && isar[LO_W-1:0] == LO_W'(6)) |=> bank_end); // R6

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b01) |=> (isar == $past(ld_val))); // R7

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b11) |=> (isar[LO_W-1:0] == $past(ld_val[LO_W-1:0]))); // R7

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ld_op == 2'b10) |=> (isar[AW-1:LO_W] == $past(ld_val[HI_W-1:0]) &&
                          $stable(isar[LO_W-1:0]))); // R7
endmodule

bind scratch_regfile scratch_regfile_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/scratch_regfile_tb.sv
module scratch_regfile_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en, rd_ind, wr_en, wr_ind;
  logic [3:0] rd_dir, wr_dir;
  logic [7:0] rd_data, wr_data;
  logic [1:0] step, ld_op;
  logic [5:0] ld_val, isar;
  logic       bank_end;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  scratch_regfile u_dut (.*);

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] op;
    logic [5:0] val;
    logic [1:0] stp;
    logic       re, ri;
    logic [3:0] rdir;
    logic       we, wi;
    logic [3:0] wdir;
    logic [7:0] wdat;
    logic [7:0] exp_rd;
    logic [5:0] exp_isar;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{4'd7, 2'd1, 6'd16, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 6'd16}, // R7 full load
    '{4'd3, 2'd0, 6'd0,  2'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h5B, 6'd17}, // R3 R4
    '{4'd4, 2'd0, 6'd0,  2'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h80, 6'd18}, // R4
    '{4'd7, 2'd3, 6'd7,  2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 6'd23}, // R7 low load
    '{4'd4, 2'd0, 6'd0,  2'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h5E, 6'd16}, // R4 wrap up
    '{4'd4, 2'd0, 6'd0,  2'd2, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h5B, 6'd23}, // R4 wrap down
    '{4'd4, 2'd0, 6'd0,  2'd2, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h5E, 6'd22}, // R4
    '{4'd8, 2'd0, 6'd0,  2'd0, 1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  8'hA5, 8'h39, 6'd22}, // R8 old data
    '{4'd8, 2'd0, 6'd0,  2'd0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'hA5, 6'd22}, // R8 new data
    '{4'd7, 2'd2, 6'd4,  2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 6'd38}, // R7 high load
    '{4'd5, 2'd0, 6'd0,  2'd1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 6'd38}, // R5 idle
    '{4'd5, 2'd0, 6'd0,  2'd1, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 4'd0,  8'h00, 8'hC4, 6'd38}, // R5 direct
    '{4'd3, 2'd0, 6'd0,  2'd1, 1'b1, 1'b0, 4'd8,  1'b1, 1'b1, 4'd0,  8'h3C, 8'h33, 6'd39}, // R3 ind write
    '{4'd4, 2'd0, 6'd0,  2'd2, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'hAE, 6'd38}, // R4
    '{4'd3, 2'd0, 6'd0,  2'd0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h3C, 6'd38}, // R3
    '{4'd7, 2'd1, 6'd63, 2'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h3C, 6'd63}, // R7 priority
    '{4'd4, 2'd0, 6'd0,  2'd1, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h26, 6'd56}, // R4 top bank
    '{4'd4, 2'd0, 6'd0,  2'd0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h23, 6'd56}, // R4 hold
    '{4'd2, 2'd0, 6'd0,  2'd0, 1'b1, 1'b0, 4'd15, 1'b1, 1'b0, 4'd15, 8'h77, 8'h36, 6'd56}, // R2 R8
    '{4'd2, 2'd0, 6'd0,  2'd0, 1'b1, 1'b0, 4'd15, 1'b0, 1'b0, 4'd0,  8'h00, 8'h77, 6'd56}, // R2
    '{4'd4, 2'd0, 6'd0,  2'd3, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  8'h00, 8'h23, 6'd56}  // R4 code 11
  };

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; rd_ind = 0; rd_dir = 0; wr_en = 0; wr_ind = 0; wr_dir = 0;
    wr_data = 0; step = 0; ld_op = 0; ld_val = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset isar", 8'(isar), 8'h00);
    chk("R1 reset bank_end", 8'(bank_end), 8'h00);
    rst = 0;

    for (int a = 0; a < 64; a++) begin
      @(negedge clk); idle();
      if (a < 16) begin
        wr_en = 1; wr_dir = 4'(a); wr_data = pat(a);
      end else begin
        ld_op = 2'b01; ld_val = 6'(a);
        @(negedge clk); idle();
        wr_en = 1; wr_ind = 1; wr_data = pat(a);
      end
    end
    @(negedge clk); idle();

    for (int a = 0; a < 16; a++) begin
      @(negedge clk); idle(); rd_dir = 4'(a); #2;
      chk("R2 direct readback", rd_data, pat(a));
    end
    for (int b = 2; b < 8; b++) begin
      @(negedge clk); idle(); ld_op = 2'b01; ld_val = 6'(b * 8);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); idle(); rd_en = 1; rd_ind = 1; step = 2'b01; #2;
        chk("R9 indirect readback", rd_data, pat(b * 8 + i));
        chk("R6 bank_end", 8'(bank_end), 8'(i == 7));
      end
      @(negedge clk); idle();
      chk("R4 bank wrap", 8'(isar), 8'(b * 8));
    end

    for (int k = 0; k < NV; k++) begin
      @(negedge clk); idle();
      ld_op = TBL[k].op; ld_val = TBL[k].val; step = TBL[k].stp;
      rd_en = TBL[k].re; rd_ind = TBL[k].ri; rd_dir = TBL[k].rdir;
      wr_en = TBL[k].we; wr_ind = TBL[k].wi; wr_dir = TBL[k].wdir; wr_data = TBL[k].wdat;
      #2;
      if (TBL[k].re) chk($sformatf("R%0d vec %0d read", TBL[k].req, k), rd_data, TBL[k].exp_rd);
      @(posedge clk); #1;
      chk($sformatf("R%0d vec %0d isar", TBL[k].req, k), 8'(isar), 8'(TBL[k].exp_isar));
      chk($sformatf("R6 vec %0d bank_end", k), 8'(bank_end), 8'(&TBL[k].exp_isar[2:0]));
    end

    @(negedge clk); idle(); ld_op = 2'b01; ld_val = 6'd31;
    @(negedge clk); idle();
    chk("R6 bank_end before reset", 8'(bank_end), 8'h01);
    rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 mid-run reset isar", 8'(isar), 8'h00);
    chk("R1 mid-run reset bank_end", 8'(bank_end), 8'h00);
    finish_run();
  end
endmodule